// File: doc/BRIEF.md
# Monotonic Security Level Register

This block keeps the security configuration that a boot subsystem acts on. The fuse shadow values come in on static inputs and set the floor. Two requesters can add to that floor. The boot image header requester presents a request with a valid strobe. The software requester writes an option register. A request can only make the configuration stricter. Requests that would loosen a setting have no effect.

The block drives these effective controls: authentication required, decryption required, long key, and root key source. It also decides whether the processor stays in the debug scan chain and whether software may change that. A cold reset discards every raised setting. A warm reset discards only the features selected by a per-feature mask parameter. The features outside the mask keep their raised values until the next cold reset. Software can read the fuse view and the effective view side by side.

Top module: `sec_level_reg`

## Requirements
- R1: After cold reset with no requests, the outputs follow the fuses. auth_req equals fuse_auth, dec_req equals fuse_dec, key_long equals fuse_klen and key_src equals fuse_ksrc. A fuse bit of 1 is a blown fuse and means the stricter setting.
- R2: A header request (hdr_vld high at a clock edge) ORs hdr_auth, hdr_dec and hdr_klen into the raised flags. The result is visible right after that edge. A 0 in a header field never clears a setting.
- R3: A software write (sw_we high at an edge) raises settings from that edge on. The write data layout is: bit 0 authentication, bit 1 decryption, bit 2 long key, bits 4:3 key source, bit 5 debug removal. A later write of 0 never lowers anything.
- R4: Key source codes are ranked as follows: 00 (fuse-held key hash) is rank 2, 01 (on-chip key memory) is rank 1, and 10 and 11 (image-carried key) are rank 0. key_src is the highest-ranked value among the fuse value and all requests. On a tie the older value is kept, and the fuse is oldest. In the same cycle a header request counts as older than a software write.
- R5: When warm_rst is high at an edge, the raised value of each feature whose WARM_CLR bit is set is cleared, including any request for it in that same cycle. The WARM_CLR bits are: [0] authentication, [1] decryption, [2] long key, [3] key source, [4] debug removal. The other features keep their raised values and still merge same-cycle requests.
- R6: Cold reset (cold_rst_n low) returns every output to the fuse values.
- R7: With both debug fuse bits at 0, jtag_en and jtag_sw_ctl are 1. A software write with bit 5 set drives jtag_en to 0.
- R8: With fuse_dbg_dis 0 and fuse_dbg_lock 1, jtag_en is 1 and jtag_sw_ctl is 0. Write bit 5 has no effect.
- R9: With fuse_dbg_dis 1, jtag_en and jtag_sw_ctl are 0 whatever the lock bit is.
- R10: Both read ports use the same layout: [0] authentication, [1] decryption, [2] long key, [4:3] key source, [5] debug, [6] debug lock. rd_fuse carries the fuse inputs, with [5] = fuse_dbg_dis and [6] = fuse_dbg_lock. rd_eff carries the effective values, with [5] = !jtag_en and [6] = !jtag_sw_ctl.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst_n | input | 1 | Asynchronous cold reset, active low |
| warm_rst | input | 1 | Synchronous warm reset, active high |
| fuse_auth | input | 1 | Fuse: authentication required |
| fuse_dec | input | 1 | Fuse: decryption required |
| fuse_klen | input | 1 | Fuse: long key |
| fuse_ksrc | input | 2 | Fuse: root key source code |
| fuse_dbg_dis | input | 1 | Fuse: debug disable |
| fuse_dbg_lock | input | 1 | Fuse: debug lock |
| hdr_vld | input | 1 | Header request strobe |
| hdr_auth | input | 1 | Header: raise authentication |
| hdr_dec | input | 1 | Header: raise decryption |
| hdr_klen | input | 1 | Header: raise key length |
| hdr_ksrc | input | 2 | Header: key source request |
| sw_we | input | 1 | Software option write strobe |
| sw_wdata | input | 6 | Software option write data |
| auth_req | output | 1 | Effective authentication required |
| dec_req | output | 1 | Effective decryption required |
| key_long | output | 1 | Effective long key |
| key_src | output | 2 | Effective root key source |
| jtag_en | output | 1 | Processor present in debug chain |
| jtag_sw_ctl | output | 1 | Software may change debug access |
| rd_fuse | output | 7 | Fuse view for software |
| rd_eff | output | 7 | Effective view for software |

## Verification
The bench uses the default warm mask, 5'b10110. With that mask, decryption, key length and debug removal are cleared by a warm reset, while authentication and key source persist, so both warm-reset behaviours are observed. The fuse space is small, so the bench walks all 128 fuse combinations. Each combination gets its own header pattern and software pattern. Across the sweep this reaches every key source tie and ranking pair and all three debug fuse policies. It also reaches warm resets that coincide with requests.

// File: rtl/sec_level_reg.sv
module sec_level_reg #(
  parameter logic [4:0] WARM_CLR = 5'b10110
) (
  input  logic       clk,
  input  logic       cold_rst_n,
  input  logic       warm_rst,
  input  logic       fuse_auth,
  input  logic       fuse_dec,
  input  logic       fuse_klen,
  input  logic [1:0] fuse_ksrc,
  input  logic       fuse_dbg_dis,
  input  logic       fuse_dbg_lock,
  input  logic       hdr_vld,
  input  logic       hdr_auth,
  input  logic       hdr_dec,
  input  logic       hdr_klen,
  input  logic [1:0] hdr_ksrc,
  input  logic       sw_we,
  input  logic [5:0] sw_wdata,
  output logic       auth_req,
  output logic       dec_req,
  output logic       key_long,
  output logic [1:0] key_src,
  output logic       jtag_en,
  output logic       jtag_sw_ctl,
  output logic [6:0] rd_fuse,
  output logic [6:0] rd_eff
);
  localparam logic [3:0] FL_WCLR = {WARM_CLR[4], WARM_CLR[2:0]};
  localparam logic [1:0] KS_NONE = 2'b10;

  function automatic logic [1:0] ks_rank(input logic [1:0] c);
    case (c)
      2'b00:   return 2'd2;
      2'b01:   return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic [1:0] ks_pick(input logic [1:0] older, input logic [1:0] newer);
    return (ks_rank(newer) > ks_rank(older)) ? newer : older;
  endfunction

  // raised flags: [0] auth, [1] dec, [2] klen, [3] debug removal
  logic [3:0] r_fl, fl_req, fl_nxt;
  logic [1:0] r_ks, ks_h, ks_s, ks_nxt;

  assign fl_req = ({4{hdr_vld}} & {1'b0, hdr_klen, hdr_dec, hdr_auth})
                | ({4{sw_we}}  & {sw_wdata[5], sw_wdata[2:0]});
  assign fl_nxt = (r_fl | fl_req) & ~(warm_rst ? FL_WCLR : 4'b0000);

  assign ks_h   = hdr_vld ? ks_pick(r_ks, hdr_ksrc) : r_ks;
  assign ks_s   = sw_we ? ks_pick(ks_h, sw_wdata[4:3]) : ks_h;
  assign ks_nxt = (warm_rst && WARM_CLR[3]) ? KS_NONE : ks_s;

  always_ff @(posedge clk or negedge cold_rst_n) begin
    if (!cold_rst_n) begin
      r_fl <= 4'b0000;
      r_ks <= KS_NONE;
    end else begin
      r_fl <= fl_nxt;
      r_ks <= ks_nxt;
    end
  end

  assign auth_req    = fuse_auth | r_fl[0];
  assign dec_req     = fuse_dec  | r_fl[1];
  assign key_long    = fuse_klen | r_fl[2];
  assign key_src     = ks_pick(fuse_ksrc, r_ks);
  assign jtag_en     = !fuse_dbg_dis && (fuse_dbg_lock || !r_fl[3]);
  assign jtag_sw_ctl = !fuse_dbg_dis && !fuse_dbg_lock;

  assign rd_fuse = {fuse_dbg_lock, fuse_dbg_dis, fuse_ksrc, fuse_klen, fuse_dec, fuse_auth};
  assign rd_eff  = {!jtag_sw_ctl, !jtag_en, key_src, key_long, dec_req, auth_req};

  a_r3_flags_no_drop: assert property (@(posedge clk) disable iff (!cold_rst_n)
    !warm_rst |=> ((r_fl & $past(r_fl)) == $past(r_fl)));

  a_r4_ksrc_no_drop: assert property (@(posedge clk) disable iff (!cold_rst_n)
    !warm_rst |=> (ks_rank(r_ks) >= ks_rank($past(r_ks))));

  a_r5_warm_keep: assert property (@(posedge clk) disable iff (!cold_rst_n)
    warm_rst |=> ((r_fl & ~FL_WCLR & $past(r_fl)) == ($past(r_fl) & ~FL_WCLR)));

  a_r5_warm_clear: assert property (@(posedge clk) disable iff (!cold_rst_n)
    warm_rst |=> ((r_fl & FL_WCLR) == 4'b0000));

  a_r3_sw_auth_now: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (sw_we && sw_wdata[0] && !warm_rst) |=> auth_req);

  a_r2_hdr_dec_now: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (hdr_vld && hdr_dec && !(warm_rst && WARM_CLR[1])) |=> dec_req);

  a_r7_sw_removes_dbg: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (sw_we && sw_wdata[5] && !(warm_rst && WARM_CLR[4]) && !fuse_dbg_lock) |=> !jtag_en);
endmodule

// File: tb/sec_level_reg_tb.sv
module sec_level_reg_tb;
  localparam int CLK_P = 10;
  localparam logic [4:0] WCLR = 5'b10110;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic cold_rst_n = 1'b0, warm_rst = 1'b0;
  logic fuse_auth = 0, fuse_dec = 0, fuse_klen = 0, fuse_dbg_dis = 0, fuse_dbg_lock = 0;
  logic [1:0] fuse_ksrc = 2'b00;
  logic hdr_vld = 0, hdr_auth = 0, hdr_dec = 0, hdr_klen = 0;
  logic [1:0] hdr_ksrc = 2'b00;
  logic sw_we = 0;
  logic [5:0] sw_wdata = 6'd0;
  logic auth_req, dec_req, key_long, jtag_en, jtag_sw_ctl;
  logic [1:0] key_src;
  logic [6:0] rd_fuse, rd_eff;

  sec_level_reg #(.WARM_CLR(WCLR)) u_dut (
    .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst(warm_rst),
    .fuse_auth(fuse_auth), .fuse_dec(fuse_dec), .fuse_klen(fuse_klen), .fuse_ksrc(fuse_ksrc),
    .fuse_dbg_dis(fuse_dbg_dis), .fuse_dbg_lock(fuse_dbg_lock),
    .hdr_vld(hdr_vld), .hdr_auth(hdr_auth), .hdr_dec(hdr_dec), .hdr_klen(hdr_klen), .hdr_ksrc(hdr_ksrc),
    .sw_we(sw_we), .sw_wdata(sw_wdata),
    .auth_req(auth_req), .dec_req(dec_req), .key_long(key_long), .key_src(key_src),
    .jtag_en(jtag_en), .jtag_sw_ctl(jtag_sw_ctl), .rd_fuse(rd_fuse), .rd_eff(rd_eff));

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [3:0] m_fl;
  logic [1:0] m_ks;

  function automatic int rk(input logic [1:0] c);
    return (c == 2'b00) ? 2 : (c == 2'b01) ? 1 : 0;
  endfunction
  function automatic logic [1:0] best(input logic [1:0] a, input logic [1:0] b);
    return (rk(b) > rk(a)) ? b : a;
  endfunction

  function automatic logic [6:0] exp_out();
    logic je, sc;
    je = !fuse_dbg_dis && (fuse_dbg_lock || !m_fl[3]);
    sc = !fuse_dbg_dis && !fuse_dbg_lock;
    return {!sc, !je, best(fuse_ksrc, m_ks), fuse_klen | m_fl[2], fuse_dec | m_fl[1], fuse_auth | m_fl[0]};
  endfunction

  task automatic chk(input string tag, input logic [6:0] got, input logic [6:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic chk_main(input string tag);
    chk(tag, {!jtag_sw_ctl, !jtag_en, key_src, key_long, dec_req, auth_req}, exp_out());
  endtask

  task automatic chk_ksrc();
    chk("R4", {5'd0, key_src}, {5'd0, best(fuse_ksrc, m_ks)});
  endtask

  task automatic chk_dbg();
    logic [6:0] e;
    e = exp_out();
    if (fuse_dbg_dis)       chk("R9", {5'd0, jtag_sw_ctl, jtag_en}, {5'd0, !e[6], !e[5]});
    else if (fuse_dbg_lock) chk("R8", {5'd0, jtag_sw_ctl, jtag_en}, {5'd0, !e[6], !e[5]});
    else                    chk("R7", {5'd0, jtag_sw_ctl, jtag_en}, {5'd0, !e[6], !e[5]});
  endtask

  task automatic chk_rd();
    chk("R10", rd_fuse, {fuse_dbg_lock, fuse_dbg_dis, fuse_ksrc, fuse_klen, fuse_dec, fuse_auth});
    chk("R10", rd_eff, exp_out());
  endtask

  task automatic do_cold();
    @(negedge clk);
    cold_rst_n = 0;
    m_fl = 4'b0000;
    m_ks = 2'b10;
    @(negedge clk);
    cold_rst_n = 1;
    #1;
  endtask

  task automatic do_req(input logic wr, input logic hv, input logic [2:0] h, input logic [1:0] hks,
                        input logic sv, input logic [5:0] w);
    @(negedge clk);
    warm_rst = wr; hdr_vld = hv; {hdr_klen, hdr_dec, hdr_auth} = h; hdr_ksrc = hks;
    sw_we = sv; sw_wdata = w;
    @(posedge clk);
    #1;
    warm_rst = 0; hdr_vld = 0; sw_we = 0;
    if (hv) begin
      m_fl[2:0] = m_fl[2:0] | h;
      m_ks = best(m_ks, hks);
    end
    if (sv) begin
      m_fl = m_fl | {w[5], w[2:0]};
      m_ks = best(m_ks, w[4:3]);
    end
    if (wr) begin
      m_fl = m_fl & ~{WCLR[4], WCLR[2:0]};
      if (WCLR[3]) m_ks = 2'b10;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    m_fl = 4'b0000;
    m_ks = 2'b10;
    for (int i = 0; i < 128; i++) begin
      logic [6:0] f;
      logic [5:0] w;
      f = i[6:0];
      {fuse_dbg_lock, fuse_dbg_dis, fuse_ksrc, fuse_klen, fuse_dec, fuse_auth} = f;
      do_cold();
      chk_main("R1");
      chk_rd();
      chk_dbg();
      // header request
      do_req(0, 1, f[2:0] ^ 3'b101, 2'(i >> 2) ^ 2'(i), 0, 6'd0);
      chk_main("R2");
      chk_ksrc();
      // software raise
      w = 6'(i * 7 + 3);
      do_req(0, 0, 3'd0, 2'd0, 1, w);
      chk_main("R3");
      chk_ksrc();
      chk_rd();
      // writing zeros must not lower
      do_req(0, 0, 3'd0, 2'd0, 1, 6'd0);
      chk_main("R3");
      // debug removal request
      do_req(0, 0, 3'd0, 2'd0, 1, {1'b1, 2'(i + 1), 3'b000});
      chk_dbg();
      chk_ksrc();
      // warm reset together with requests
      do_req(1, 1, 3'b111, 2'(i), (i % 2) == 1, {3'b101, 2'(i >> 1), 1'b1});
      chk_main("R5");
      do_req(1, 0, 3'd0, 2'd0, 0, 6'd0);
      chk_main("R5");
      do_cold();
      chk_main("R6");
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule